// File: doc/BRIEF.md
# Sub-Audio Squelch Path Mode Controller

This block decides, every clock cycle, how the sub-audio tone and voice paths of a half-duplex tone-squelch transceiver are routed. It looks at four latched control bits: the receive/transmit select, the listen-override bit, a flag that marks the programmed tone code as "no tone", and the digital result of the tone-decode comparator. From these it produces the tone generator state, a tone phase-reversal strobe, the transmit and receive voice-path enables, and a threshold select for the comparator reference.

In transmit, the listen-override bit changes meaning and flips the phase of the outgoing tone. This is used to remove the squelch tail at the far receiver. In receive, the same bit opens the voice path whatever the squelch state. A "no tone" code turns the tone generator into a steady bias level in transmit and leaves the receive voice path open in receive. All outputs are registered, so downstream analog switches see only clean transitions.

Top module: `ctcss_path_ctrl`

## Requirements
- R1: In transmit (`rx_sel`=0) with a real tone code (`no_tone`=0), `tone_state` is 2'b10 (tone active), `tx_audio_en`=1 and `rx_audio_en`=0.
- R2: In transmit with a real tone code, `tone_invert` equals `ptl`: 1 reverses the tone phase and 0 leaves it normal.
- R3: In transmit with `no_tone`=1, `tone_state` is 2'b01 (bias level), `tx_audio_en`=1, `rx_audio_en`=0 and `tone_invert`=0.
- R4: In receive (`rx_sel`=1), `tone_state` is 2'b00 (open circuit), `tx_audio_en`=0 and `tone_invert`=0.
- R5: In receive, `rx_audio_en` is 1 when at least one of these holds: `dec_n`=0 (tone detected, active low), `ptl`=1, or `no_tone`=1. It is 0 only when `dec_n`=1, `ptl`=0 and `no_tone`=0.
- R6: In receive with a tone detected (`dec_n`=0), changing `ptl` has no effect on any output.
- R7: `thr_high` follows the decode level, so `dec_n`=1 selects the high reference and `dec_n`=0 selects the low one. This gives the comparator hysteresis.
- R8: Every output changes exactly one rising clock edge after its inputs change. While `rst` is high, the outputs hold `tone_state`=2'b00, `tone_invert`=0, `tx_audio_en`=0, `rx_audio_en`=0 and `thr_high`=1.
- R9: `tone_state` never takes the unused code 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_sel | input | 1 | 1 = receive, 0 = transmit |
| ptl | input | 1 | Listen override in receive, phase reverse in transmit |
| no_tone | input | 1 | Programmed tone code is "no tone" |
| dec_n | input | 1 | Tone-decode comparator result, 0 = tone detected |
| tone_state | output | 2 | Tone output drive: 00 open, 01 bias, 10 tone |
| tone_invert | output | 1 | Reverse phase of transmitted tone |
| tx_audio_en | output | 1 | Transmit voice path enable |
| rx_audio_en | output | 1 | Receive voice path enable |
| thr_high | output | 1 | Comparator reference select, 1 = high threshold |

## Verification
All sixteen combinations of the four control inputs are applied twice: once in counting order and once in reverse Gray order. The counting order isolates each bit's effect on the squelch decision. The Gray walk flips one bit at a time, so a wrong dependency shows up as an unexpected output change, for example `ptl` leaking into receive after detection, or `no_tone` into the transmit audio enable. Each step also samples the outputs before the next edge to confirm the one-cycle latency, and a reset phase with active inputs confirms the reset values.

// File: rtl/ctcss_mode_pkg.sv
package ctcss_mode_pkg;

    localparam int TONE_SEL_W = 2;

    typedef enum logic [TONE_SEL_W-1:0] {
        TONE_OPEN   = 2'b00,
        TONE_BIAS   = 2'b01,
        TONE_ACTIVE = 2'b10
    } tone_sel_e;

    typedef struct packed {
        tone_sel_e tone;
        logic      invert;
        logic      tx_en;
        logic      rx_en;
        logic      thr_high;
    } path_ctrl_t;

    localparam path_ctrl_t PATH_RESET = '{
        tone:     TONE_OPEN,
        invert:   1'b0,
        tx_en:    1'b0,
        rx_en:    1'b0,
        thr_high: 1'b1
    };

    // Receive squelch: detection is active low.
    function automatic logic squelch_open(input logic det_n, input logic ovr,
                                          input logic nt);
        return (~det_n) | ovr | nt;
    endfunction

endpackage

// File: rtl/ctcss_tx_ctrl.sv
module ctcss_tx_ctrl
    import ctcss_mode_pkg::*;
(
    input  logic      no_tone,
    input  logic      ptl,
    output tone_sel_e tone,
    output logic      invert
);
    always_comb begin
        if (no_tone) begin
            tone   = TONE_BIAS;
            invert = 1'b0;
        end else begin
            tone   = TONE_ACTIVE;
            invert = ptl;
        end
    end
endmodule

// File: rtl/ctcss_rx_ctrl.sv
module ctcss_rx_ctrl
    import ctcss_mode_pkg::*;
(
    input  logic dec_n,
    input  logic ptl,
    input  logic no_tone,
    output logic rx_open,
    output logic thr_high
);
    always_comb begin
        rx_open  = squelch_open(dec_n, ptl, no_tone);
        thr_high = dec_n;
    end
endmodule

// File: rtl/ctcss_out_reg.sv
module ctcss_out_reg
    import ctcss_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  path_ctrl_t d,
    output path_ctrl_t q
);
    always_ff @(posedge clk) begin
        if (rst) q <= PATH_RESET;
        else     q <= d;
    end
endmodule

// File: rtl/ctcss_path_ctrl.sv
module ctcss_path_ctrl
    import ctcss_mode_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_sel,
    input  logic       ptl,
    input  logic       no_tone,
    input  logic       dec_n,
    output logic [1:0] tone_state,
    output logic       tone_invert,
    output logic       tx_audio_en,
    output logic       rx_audio_en,
    output logic       thr_high
);
    tone_sel_e  tx_tone;
    logic       tx_inv;
    logic       rx_open;
    logic       rx_thr;
    path_ctrl_t nxt;
    path_ctrl_t cur;

    ctcss_tx_ctrl u_tx (
        .no_tone (no_tone),
        .ptl     (ptl),
        .tone    (tx_tone),
        .invert  (tx_inv)
    );

    ctcss_rx_ctrl u_rx (
        .dec_n    (dec_n),
        .ptl      (ptl),
        .no_tone  (no_tone),
        .rx_open  (rx_open),
        .thr_high (rx_thr)
    );

    // Direction select: each side owns its outputs only in its own mode.
    always_comb begin
        nxt          = PATH_RESET;
        nxt.thr_high = rx_thr;
        if (rx_sel) begin
            nxt.tone  = TONE_OPEN;
            nxt.rx_en = rx_open;
        end else begin
            nxt.tone   = tx_tone;
            nxt.invert = tx_inv;
            nxt.tx_en  = 1'b1;
        end
    end

    ctcss_out_reg u_reg (
        .clk (clk),
        .rst (rst),
        .d   (nxt),
        .q   (cur)
    );

    assign tone_state  = cur.tone;
    assign tone_invert = cur.invert;
    assign tx_audio_en = cur.tx_en;
    assign rx_audio_en = cur.rx_en;
    assign thr_high    = cur.thr_high;

    AST_TX_TONE_ON: assert property (@(posedge clk) disable iff (rst)
        (!rx_sel && !no_tone) |=> (tone_state == 2'b10 && tx_audio_en && !rx_audio_en)); // R1
    AST_TX_PHASE: assert property (@(posedge clk) disable iff (rst)
        (!rx_sel && !no_tone) |=> (tone_invert == $past(ptl))); // R2
    AST_TX_BIAS: assert property (@(posedge clk) disable iff (rst)
        (!rx_sel && no_tone) |=> (tone_state == 2'b01 && tx_audio_en && !rx_audio_en && !tone_invert)); // R3
    AST_RX_OPEN_CCT: assert property (@(posedge clk) disable iff (rst)
        rx_sel |=> (tone_state == 2'b00 && !tx_audio_en && !tone_invert)); // R4
    AST_RX_SQUELCH: assert property (@(posedge clk) disable iff (rst)
        (rx_sel && dec_n && !ptl && !no_tone) |=> !rx_audio_en); // R5
    AST_RX_DETECT: assert property (@(posedge clk) disable iff (rst)
        (rx_sel && !dec_n) |=> rx_audio_en); // R6
    AST_HYST_HIGH: assert property (@(posedge clk) disable iff (rst)
        dec_n |=> thr_high); // R7
    AST_HYST_LOW: assert property (@(posedge clk) disable iff (rst)
        !dec_n |=> !thr_high); // R7
    AST_RESET_VAL: assert property (@(posedge clk)
        rst |=> (tone_state == 2'b00 && !tx_audio_en && !rx_audio_en && thr_high)); // R8
    AST_TONE_CODE: assert property (@(posedge clk) disable iff (rst)
        tone_state != 2'b11); // R9

endmodule

// File: tb/ctcss_path_ctrl_bench.sv
module ctcss_path_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       rx_sel, ptl, no_tone, dec_n;
    logic [1:0] tone_state;
    logic       tone_invert, tx_audio_en, rx_audio_en, thr_high;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    ctcss_path_ctrl u_ctcss_path_ctrl (
        .clk (clk), .rst (rst),
        .rx_sel (rx_sel), .ptl (ptl), .no_tone (no_tone), .dec_n (dec_n),
        .tone_state (tone_state), .tone_invert (tone_invert),
        .tx_audio_en (tx_audio_en), .rx_audio_en (rx_audio_en),
        .thr_high (thr_high)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected outputs packed as {tone[1:0], inv, tx, rx, thr}
    function automatic logic [5:0] model(input logic [3:0] v);
        logic r, p, n, d;
        logic [1:0] t;
        {r, p, n, d} = v;
        if (r) t = 2'd0;
        else   t = n ? 2'd1 : 2'd2;
        return {t, (!r && !n && p), !r, (r && (!d || p || n)), d};
    endfunction

    task automatic check_all(input logic [3:0] v, input logic [5:0] e);
        string rq;
        rq = v[3] ? "R4" : (v[1] ? "R3" : "R1");
        check(rq, "tone_state", tone_state, e[5:4]);
        check(v[3] ? "R4" : "R2", "tone_invert", tone_invert, e[3]);
        check(rq, "tx_audio_en", tx_audio_en, e[2]);
        check((v[3] && !v[0]) ? "R6" : "R5", "rx_audio_en", rx_audio_en, e[1]);
        check("R7", "thr_high", thr_high, e[0]);
        check("R9", "tone code legal", int'(tone_state != 2'b11), 1);
    endtask

    task automatic apply(input logic [3:0] v, input logic [5:0] prev);
        {rx_sel, ptl, no_tone, dec_n} = v;
        #1;
        // Outputs must still show the previous setting (R8 latency).
        check("R8", "held before edge", {tone_state, tone_invert, tx_audio_en, rx_audio_en, thr_high}, prev);
        @(negedge clk);
        check_all(v, model(v));
    endtask

    initial begin
        logic [5:0] last;
        rst = 1'b1;
        {rx_sel, ptl, no_tone, dec_n} = 4'b0100;
        repeat (3) @(negedge clk);
        check("R8", "reset tone_state", tone_state, 0);
        check("R8", "reset tone_invert", tone_invert, 0);
        check("R8", "reset tx_audio_en", tx_audio_en, 0);
        check("R8", "reset rx_audio_en", rx_audio_en, 0);
        check("R8", "reset thr_high", thr_high, 1);
        rst = 1'b0;
        {rx_sel, ptl, no_tone, dec_n} = 4'b1001;
        @(negedge clk);
        last = model(4'b1001);
        for (int i = 0; i < 16; i++) begin
            apply(4'(i), last);
            last = model(4'(i));
        end
        for (int i = 15; i >= 0; i--) begin
            logic [3:0] g;
            g = 4'(i) ^ (4'(i) >> 1);
            apply(g, last);
            last = model(g);
        end
        // R6: with detection in receive, toggling ptl changes nothing.
        apply(4'b1000, last);
        last = model(4'b1000);
        apply(4'b1100, last);
        check("R6", "rx_audio_en ptl ignored", rx_audio_en, 1);
        check("R6", "tone_invert ptl ignored", tone_invert, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule